// File: doc/BRIEF.md
# Predicate Register File with Paired Compare Writes

This block holds the one-bit guard flags of a predicated processor: a file of predicates that later instructions name with a 6-bit index to decide whether they take effect. Compare operations fill the file. Each compare lane takes two 64-bit operands and a relation code, and it writes the outcome to one target predicate and the inverse of the outcome to a second target. Both writes happen in a single operation.

Every compare is itself guarded by a qualifying predicate. In the plain form, a false guard cancels the compare and neither target changes. In the clearing form, a false guard still writes both targets, and it writes zero to each. Several compare lanes can complete in the same clock cycle. The lanes are ordered as program order, and the later write to a predicate wins. Combinational read ports tell the issue logic whether the guard of an instruction is currently true.

Top module: `pred_compare_file`

## Requirements
- R1: After reset every predicate reads 0, except predicate 0.
- R2: Predicate 0 always reads 1. A compare that names predicate 0 as a target leaves it reading 1.
- R3: Relation code 0 tests equal, 1 tests not equal, 2 tests A less than B, and 3 tests A greater than B. Less-than and greater-than treat the 64-bit operands as two's complement numbers. A lane whose compare is enabled writes the test result to its first target and the inverse of the result to its second target. The new values are visible on the read ports after the next rising clock edge.
- R4: When the lane's clearing flag is low and its qualifying predicate reads 0, the compare has no effect on any predicate.
- R5: When the lane's clearing flag is high and its qualifying predicate reads 0, both targets are written with 0.
- R6: When the lane's clearing flag is high and its qualifying predicate reads 1, the lane behaves exactly as an ordinary compare.
- R7: The qualifying predicate of a lane is read from the state held before the current edge. A compare in another lane of the same cycle does not change which guard value a lane sees.
- R8: Up to three lanes can write in one cycle. On a conflict, a higher-numbered lane overrides a lower-numbered one. Within one lane, the second target's write overrides the first target's write when both name the same predicate.
- R9: Each read port returns the current stored value of the predicate selected by its index, with no clock delay.
- R10: A lane whose valid bit is low changes nothing, whatever its other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 3 | One valid bit per compare lane; lane 0 is oldest in program order |
| cmp_rel | input | 6 | Relation code, 2 bits per lane |
| cmp_unc | input | 3 | Clearing-form flag per lane |
| cmp_qp | input | 18 | Qualifying predicate index, 6 bits per lane |
| cmp_ta | input | 18 | First target index (receives the result), 6 bits per lane |
| cmp_tb | input | 18 | Second target index (receives the inverse), 6 bits per lane |
| cmp_a | input | 192 | Operand A, 64 bits per lane |
| cmp_b | input | 192 | Operand B, 64 bits per lane |
| rd_idx | input | 12 | Read port predicate index, 6 bits per port |
| rd_en | output | 2 | Read port result: 1 when the selected predicate is true |

## Verification
The clocked properties on the stored state look only at cycles in which lane 0 is the single valid lane. For the pairing property, they also require two distinct targets, neither of them predicate 0. Each property expects the state to be disturbed by nothing but the compare stimulus, so it assumes no other lane is writing at the same time.

The directed part of the stimulus meets these conditions by construction. The sweep drives random lane mixes, with targets drawn from a small index range so that conflicts happen often. In those cycles the pairing, hold and clearing properties simply stay idle. The bench's model supplies the expected predicate values there, and every predicate is read back through the read ports after each step.

// File: rtl/pcmp_pkg.sv
`timescale 1ns/1ps
package pcmp_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_NE = 2'd1,
      REL_LT = 2'd2,
      REL_GT = 2'd3
   } rel_e;

   typedef struct packed {
      logic we_a;
      logic val_a;
      logic we_b;
      logic val_b;
   } lane_wr_t;
endpackage

// File: rtl/pcmp_lane.sv
`timescale 1ns/1ps
module pcmp_lane import pcmp_pkg::*; #(
   parameter int DATA_W     = 64,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              valid,
   input  logic [1:0]        rel,
   input  logic              unc,
   input  logic              qp_on,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output lane_wr_t          wr
);
   logic is_lt, is_gt, hit, enable_wr;

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_lt = $signed(a) < $signed(b);
         assign is_gt = $signed(a) > $signed(b);
      end else begin : g_unsigned
         assign is_lt = a < b;
         assign is_gt = a > b;
      end
   endgenerate

   always_comb begin
      case (rel_e'(rel))
         REL_EQ:  hit = (a == b);
         REL_NE:  hit = (a != b);
         REL_LT:  hit = is_lt;
         default: hit = is_gt;
      endcase
   end

   // guard true: normal pair write; guard false: only the clearing form writes (zeros)
   assign enable_wr = valid & (qp_on | unc);

   always_comb begin
      wr.we_a  = enable_wr;
      wr.we_b  = enable_wr;
      wr.val_a = qp_on & hit;
      wr.val_b = qp_on & ~hit;
   end
endmodule

// File: rtl/pcmp_store.sv
`timescale 1ns/1ps
module pcmp_store import pcmp_pkg::*; #(
   parameter int NREG  = 64,
   parameter int LANES = 3,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  lane_wr_t [LANES-1:0]   wr,
   input  logic [LANES*IDX_W-1:0] tgt_a,
   input  logic [LANES*IDX_W-1:0] tgt_b,
   output logic [NREG-1:0]        state
);
   logic [NREG-1:0] q, nxt;

   // lanes applied in program order; later assignments override earlier ones
   always_comb begin
      nxt = q;
      for (int l = 0; l < LANES; l++) begin
         if (wr[l].we_a) nxt[tgt_a[l*IDX_W +: IDX_W]] = wr[l].val_a;
         if (wr[l].we_b) nxt[tgt_b[l*IDX_W +: IDX_W]] = wr[l].val_b;
      end
      nxt[0] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= NREG'(1);
      else        q <= nxt;
   end

   assign state = q;
endmodule

// File: rtl/pcmp_rdport.sv
`timescale 1ns/1ps
module pcmp_rdport #(
   parameter int NREG = 64,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  state,
   input  logic [IDX_W-1:0] idx,
   output logic             en
);
   assign en = state[idx];
endmodule

// File: rtl/pred_compare_file.sv
`timescale 1ns/1ps
module pred_compare_file import pcmp_pkg::*; #(
   parameter int NREG       = 64,
   parameter int LANES      = 3,
   parameter int RD_PORTS   = 2,
   parameter int DATA_W     = 64,
   parameter bit SIGNED_CMP = 1'b1,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          cmp_valid,
   input  logic [2*LANES-1:0]        cmp_rel,
   input  logic [LANES-1:0]          cmp_unc,
   input  logic [LANES*IDX_W-1:0]    cmp_qp,
   input  logic [LANES*IDX_W-1:0]    cmp_ta,
   input  logic [LANES*IDX_W-1:0]    cmp_tb,
   input  logic [LANES*DATA_W-1:0]   cmp_a,
   input  logic [LANES*DATA_W-1:0]   cmp_b,
   input  logic [RD_PORTS*IDX_W-1:0] rd_idx,
   output logic [RD_PORTS-1:0]       rd_en
);
   generate
      if (NREG < 2 || NREG != (1 << IDX_W)) begin : g_bad_nreg
         $error("NREG must be a power of two and at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (RD_PORTS < 1) begin : g_bad_ports
         $error("RD_PORTS must be at least 1");
      end
   endgenerate

   logic [NREG-1:0]      pstate;
   logic [LANES-1:0]     qp_on;
   lane_wr_t [LANES-1:0] lane_wr;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         pcmp_rdport #(.NREG(NREG)) u_qp (
            .state (pstate),
            .idx   (cmp_qp[g*IDX_W +: IDX_W]),
            .en    (qp_on[g])
         );
         pcmp_lane #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_lane (
            .valid (cmp_valid[g]),
            .rel   (cmp_rel[g*2 +: 2]),
            .unc   (cmp_unc[g]),
            .qp_on (qp_on[g]),
            .a     (cmp_a[g*DATA_W +: DATA_W]),
            .b     (cmp_b[g*DATA_W +: DATA_W]),
            .wr    (lane_wr[g])
         );
      end
      for (g = 0; g < RD_PORTS; g++) begin : g_rd
         pcmp_rdport #(.NREG(NREG)) u_rd (
            .state (pstate),
            .idx   (rd_idx[g*IDX_W +: IDX_W]),
            .en    (rd_en[g])
         );
         assert_p0_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[g*IDX_W +: IDX_W] == '0) |-> rd_en[g]);
      end
   endgenerate

   pcmp_store #(.NREG(NREG), .LANES(LANES)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (lane_wr),
      .tgt_a (cmp_ta),
      .tgt_b (cmp_tb),
      .state (pstate)
   );

   logic [IDX_W-1:0] l0_ta, l0_tb;
   logic             only_l0;
   assign l0_ta   = cmp_ta[IDX_W-1:0];
   assign l0_tb   = cmp_tb[IDX_W-1:0];
   assign only_l0 = (cmp_valid == LANES'(1));

   assert_pair_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (only_l0 && qp_on[0] && l0_ta != l0_tb && l0_ta != '0 && l0_tb != '0)
      |=> (pstate[$past(l0_ta)] != pstate[$past(l0_tb)]));

   assert_guard_false_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (only_l0 && !qp_on[0] && !cmp_unc[0]) |=> $stable(pstate));

   assert_clear_form_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (only_l0 && !qp_on[0] && cmp_unc[0])
      |=> (!pstate[$past(l0_ta)] || $past(l0_ta) == '0) && (!pstate[$past(l0_tb)] || $past(l0_tb) == '0));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid == '0) |=> $stable(pstate));
endmodule

// File: tb/pred_compare_file_tb.sv
`timescale 1ns/1ps
module pred_compare_file_tb;
   localparam int L = 3;
   localparam int W = 6;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [L-1:0]   cmp_valid;
   logic [2*L-1:0] cmp_rel;
   logic [L-1:0]   cmp_unc;
   logic [L*W-1:0] cmp_qp, cmp_ta, cmp_tb;
   logic [L*64-1:0] cmp_a, cmp_b;
   logic [2*W-1:0] rd_idx;
   logic [1:0]     rd_en;

   int vectors = 0;
   int miscompares = 0;
   logic [63:0] model;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   pred_compare_file u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_rel(cmp_rel),
      .cmp_unc(cmp_unc), .cmp_qp(cmp_qp), .cmp_ta(cmp_ta), .cmp_tb(cmp_tb),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .rd_idx(rd_idx), .rd_en(rd_en)
   );

   function automatic logic rel_of(logic [1:0] r, logic [63:0] a, logic [63:0] b);
      case (r)
         2'd0:    return a == b;
         2'd1:    return a != b;
         2'd2:    return $signed(a) < $signed(b);
         default: return $signed(a) > $signed(b);
      endcase
   endfunction

   function automatic logic [63:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      return seed;
   endfunction

   task automatic chk(string req, int idx, logic got, logic exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s p%0d got %b expected %b", req, idx, got, exp);
      end
   endtask

   task automatic check_all(string req);
      @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         rd_idx = {6'(2*i+1), 6'(2*i)};
         #0.05;
         chk(req, 2*i,   rd_en[0], model[2*i]);
         chk(req, 2*i+1, rd_en[1], model[2*i+1]);
      end
   endtask

   task automatic set_lane(int l, logic v, logic [1:0] r, logic u, int qp, int ta, int tb,
                           logic [63:0] a, logic [63:0] b);
      cmp_valid[l]       = v;
      cmp_rel[l*2 +: 2]  = r;
      cmp_unc[l]         = u;
      cmp_qp[l*W +: W]   = 6'(qp);
      cmp_ta[l*W +: W]   = 6'(ta);
      cmp_tb[l*W +: W]   = 6'(tb);
      cmp_a[l*64 +: 64]  = a;
      cmp_b[l*64 +: 64]  = b;
   endtask

   // apply at the edge and update the expected state from the old state
   task automatic go();
      logic [63:0] old;
      @(posedge clk);
      old = model;
      for (int l = 0; l < L; l++) begin
         if (cmp_valid[l]) begin
            logic g, h;
            g = (cmp_qp[l*W +: W] == 0) ? 1'b1 : old[cmp_qp[l*W +: W]];
            h = rel_of(cmp_rel[l*2 +: 2], cmp_a[l*64 +: 64], cmp_b[l*64 +: 64]);
            if (g) begin
               model[cmp_ta[l*W +: W]] = h;
               model[cmp_tb[l*W +: W]] = ~h;
            end else if (cmp_unc[l]) begin
               model[cmp_ta[l*W +: W]] = 1'b0;
               model[cmp_tb[l*W +: W]] = 1'b0;
            end
         end
      end
      model[0] = 1'b1;
      #0.1;
      cmp_valid = '0;
   endtask

   task automatic idle_lanes();
      for (int l = 0; l < L; l++) set_lane(l, 1'b0, 2'd0, 1'b0, 0, 0, 0, 64'd0, 64'd0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(4.0 * 200000);
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] pa [6];
      logic [63:0] pb [6];
      pa[0] = 64'd5;  pb[0] = 64'd5;
      pa[1] = 64'd3;  pb[1] = 64'd9;
      pa[2] = 64'd9;  pb[2] = 64'd3;
      pa[3] = '1;     pb[3] = 64'd1;
      pa[4] = 64'h8000_0000_0000_0000; pb[4] = 64'h7FFF_FFFF_FFFF_FFFF;
      pa[5] = 64'h7FFF_FFFF_FFFF_FFFF; pb[5] = 64'h8000_0000_0000_0000;
      rst_n = 1'b0;
      rd_idx = '0;
      cmp_valid = '0; cmp_rel = '0; cmp_unc = '0; cmp_qp = '0;
      cmp_ta = '0; cmp_tb = '0; cmp_a = '0; cmp_b = '0;
      model = 64'd1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      // R3: every relation against several operand patterns, incl. signed extremes
      for (int p = 0; p < 6; p++) begin
         for (int r = 0; r < 4; r++) begin
            @(negedge clk); idle_lanes();
            set_lane(0, 1'b1, 2'(r), 1'b0, 0, 1 + r, 5 + r, pa[p], pb[p]);
            go();
            check_all("R3");
         end
      end

      // R4: plain form, guard p20 is 0 -> nothing changes
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 20, 1, 5, 64'd1, 64'd1);
      go(); check_all("R4");

      // R5: clearing form, guard false -> both targets 0
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b1, 20, 1, 5, 64'd1, 64'd1);
      go(); check_all("R5");

      // R6: clearing form with true guard p21 acts normally
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 0, 21, 22, 64'd7, 64'd7);
      go(); check_all("R6");
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd2, 1'b1, 21, 30, 31, 64'd1, 64'd2);
      go(); check_all("R6");

      // R7: guard sampled before same-cycle writes
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 0, 44, 46, 64'd0, 64'd0);
      go(); check_all("R7");
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 0, 40, 41, 64'd1, 64'd1);
      set_lane(1, 1'b1, 2'd0, 1'b0, 40, 42, 43, 64'd1, 64'd1);
      set_lane(2, 1'b1, 2'd0, 1'b1, 40, 44, 45, 64'd1, 64'd1);
      go(); check_all("R7");

      // R8: lane priority and same-target inside one lane
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 0, 50, 51, 64'd1, 64'd1);
      set_lane(1, 1'b1, 2'd0, 1'b0, 0, 50, 51, 64'd1, 64'd2);
      set_lane(2, 1'b1, 2'd3, 1'b0, 0, 50, 52, 64'd5, 64'd4);
      go(); check_all("R8");
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd0, 1'b0, 0, 53, 53, 64'd1, 64'd1);
      go(); check_all("R8");

      // R2: writes to p0 are ignored
      @(negedge clk); idle_lanes();
      set_lane(0, 1'b1, 2'd1, 1'b0, 0, 0, 0, 64'd1, 64'd1);
      set_lane(1, 1'b1, 2'd1, 1'b1, 20, 0, 6, 64'd1, 64'd2);
      go(); check_all("R2");

      // R10: invalid lanes with live-looking fields change nothing
      @(negedge clk);
      set_lane(0, 1'b0, 2'd1, 1'b1, 0, 50, 53, 64'd1, 64'd2);
      set_lane(1, 1'b0, 2'd0, 1'b1, 20, 30, 40, 64'd3, 64'd3);
      set_lane(2, 1'b0, 2'd2, 1'b0, 0, 21, 22, 64'd0, 64'd9);
      go(); check_all("R10");

      // R8/R9: random lane mixes over a crowded index range
      for (int s = 0; s < 300; s++) begin
         @(negedge clk);
         for (int l = 0; l < L; l++) begin
            logic [63:0] r, a, b;
            r = rnd(); a = rnd(); b = rnd();
            if (r[9:8] == 2'd0) b = a;
            set_lane(l, r[0], r[2:1], r[3], int'(r[15:12]), int'(r[19:16]), int'(r[23:20]), a, b);
         end
         go();
         check_all("R9");
      end

      summary();
      $finish;
   end
endmodule